// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port with a small register file on a simple strobe bus. Software selects the character length (7, 8 or 9 bits), the parity mode (none, even or odd) and one or two stop bits. It also chooses whether the transmitter waits for a clear-to-send input, and sets an integer divider that, together with an external prescaler tick, fixes the bit rate. Each direction has a single holding register. Status flags report receive-ready, transmit-ready, line breaks, clear-to-send changes and receive errors. One interrupt line combines every status flag whose enable is set.

The receiver samples the line at 16 times the bit rate. It confirms a start bit at its centre, then samples each following bit at its centre. The transmitter can be forced to send a break, which holds its line low. An incoming break is detected and reported, and it suspends reception until the line returns high.

Register map on `bus_addr`:

| Address | Register |
|---|---|
| 0 | configuration |
| 1 | control |
| 2 | status |
| 3 | interrupt enable set (reads back the enables) |
| 4 | interrupt enable clear |
| 5 | receive data |
| 6 | transmit data |
| 7 | divider |

Reads are combinational on `bus_rdata`. `bus_rd` only marks the cycle in which a read has side effects.

Top module: `serial_port`

## Requirements
- R1: After reset `txd` is 1, `irq` is 0, and the configuration, control and enable registers read 0. Status reads 0x0004, meaning only transmit-ready (bit 2) is set.
- R2: One bit lasts 16 × (BRG + 1) pulses of `tick_16x`, where BRG is written at address 7 and reads back from there.
- R3: Configuration bit 0 enables the port. A transmitted character is one low start bit followed by the data bits, least significant first. Configuration bits 3:2 set the data length: 0 gives 7 bits, 1 gives 8 bits, 2 gives 9 bits, and 3 acts as 8 bits.
- R4: Configuration bits 5:4 set parity: 0 or 1 is none, 2 is even, 3 is odd. The parity bit follows the data bits. Configuration bit 6 sets the stop bits, 0 for one and 1 for two, and stop bits are high.
- R5: Status bit 2 (transmit-ready) reads 0 in the cycle after a write to address 6. It returns to 1 once the character has moved into the shift register.
- R6: The receiver accepts a start bit only if the line is still low at the start bit's centre; a shorter low pulse is ignored. When the frame completes, status bit 0 is set and the data reads at address 5, right-aligned. A read of address 5 clears status bit 0.
- R7: A received parity mismatch sets status bit 14 and a low first stop bit sets status bit 13. Both flags stay set until 1 is written to their positions in the status register.
- R8: With configuration bit 9 set, a character starts only while `cts_n` is low. Any change of the synchronised `cts_n` sets status bit 5, which is cleared by writing 1 to it.
- R9: While control bit 1 is set, `txd` is held low.
- R10: A received frame that is all zero, including its stop bit, sets status bit 10. No further frame is accepted until the line returns high, and then bit 10 clears. Every change of bit 10 sets status bit 11, which is cleared by writing 1 to it.
- R11: Writing 1 to a bit at address 3 sets that interrupt enable, and writing 1 at address 4 clears it. Address 3 reads back the enables. Bit 0 is receive-ready and bit 2 is transmit-ready; bits 5, 10, 11, 13 and 14 follow the status positions.
- R12: `irq` is high exactly when some status bit and its enable are both 1.
- R13: While configuration bit 0 is 0, no character is sent, a written character stays held, and the receive line is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_16x | input | 1 | Prescaler pulse, one clock wide |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects only) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational on `bus_addr` |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| cts_n | input | 1 | Clear to send, active low |
| irq | output | 1 | Interrupt request |

## Verification
Register and flag effects of a write or a read strobe take effect at the clock edge that captures the strobe. The bench reads them back at the next falling edge. A change on `rxd` or `cts_n` reaches the flags only after two synchroniser stages, so those flags are checked several cycles later or after the whole frame. Serial bits are checked at the centre of each bit period, counted in whole bit times from the detected start edge, so a one-cycle offset in the start does not matter. The bit-rate check instead counts exact clock cycles between two edges inside a frame.

// File: rtl/serial_port.sv
module serial_port #(
  parameter int DIV_W = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_16x,
  input  logic [2:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        rxd,
  output logic        txd,
  input  logic        cts_n,
  output logic        irq
);
  localparam logic [2:0] A_CFG = 3'd0, A_CTL = 3'd1, A_STAT = 3'd2, A_IENS = 3'd3,
                         A_IENC = 3'd4, A_RXD = 3'd5, A_TXD = 3'd6, A_DIV = 3'd7;
  localparam logic [15:0] STAT_MASK = 16'h6C25;
  localparam logic [15:0] CFG_MASK  = 16'h027D;

  typedef enum logic [1:0] {R_IDLE, R_START, R_BITS} rx_state_e;

  logic [15:0] cfg, ien, stat;
  logic brk_tx;
  logic [DIV_W-1:0] brg, div_cnt;
  logic os_tick;

  wire wr_cfg  = bus_wr && bus_addr == A_CFG;
  wire wr_ctl  = bus_wr && bus_addr == A_CTL;
  wire wr_stat = bus_wr && bus_addr == A_STAT;
  wire wr_iens = bus_wr && bus_addr == A_IENS;
  wire wr_ienc = bus_wr && bus_addr == A_IENC;
  wire wr_txd  = bus_wr && bus_addr == A_TXD;
  wire wr_div  = bus_wr && bus_addr == A_DIV;
  wire rd_rxd  = bus_rd && bus_addr == A_RXD;

  wire en      = cfg[0];
  wire par_odd = cfg[4];
  wire par_en  = cfg[5];
  wire stop2   = cfg[6];
  wire cts_en  = cfg[9];

  logic [3:0] nbits;
  logic [8:0] dmask;
  always_comb begin
    case (cfg[3:2])
      2'd0:    nbits = 4'd7;
      2'd2:    nbits = 4'd9;
      default: nbits = 4'd8;
    endcase
    dmask = 9'((10'd1 << nbits) - 10'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0; brk_tx <= 1'b0; brg <= '0; ien <= '0;
    end else begin
      if (wr_cfg) cfg <= bus_wdata & CFG_MASK;
      if (wr_ctl) brk_tx <= bus_wdata[1];
      if (wr_div) brg <= bus_wdata[DIV_W-1:0];
      if (wr_iens)      ien <= ien | (bus_wdata & STAT_MASK);
      else if (wr_ienc) ien <= ien & ~bus_wdata;
    end
  end

  logic rx_s1, rx_s, cts_s1, cts_s, cts_prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s1 <= 1'b1; rx_s <= 1'b1; cts_s1 <= 1'b1; cts_s <= 1'b1; cts_prev <= 1'b1;
    end else begin
      rx_s1 <= rxd;   rx_s <= rx_s1;
      cts_s1 <= cts_n; cts_s <= cts_s1; cts_prev <= cts_s;
    end
  end

  assign os_tick = tick_16x && (div_cnt >= brg);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        div_cnt <= '0;
    else if (tick_16x) div_cnt <= os_tick ? '0 : div_cnt + 1'b1;
  end

  // transmitter
  logic [8:0]  hold;
  logic        hold_full, tx_busy, pbit;
  logic [12:0] tsh, frame;
  logic [3:0]  tcnt, tidx, tlen, tlen_q;

  always_comb begin
    pbit  = (^(hold & dmask)) ^ par_odd;
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 9; i++)
      if (i < int'(nbits)) frame[i+1] = hold[i];
    if (par_en) frame[nbits + 4'd1] = pbit;
    tlen = 4'd1 + nbits + {3'b0, par_en} + (stop2 ? 4'd2 : 4'd1);
  end

  wire tx_go = en && hold_full && !tx_busy && (!cts_en || !cts_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= '0; hold_full <= 1'b0; tx_busy <= 1'b0; tsh <= '1;
      tcnt <= '0; tidx <= '0; tlen_q <= '0;
    end else begin
      if (tx_go) begin
        tsh <= frame; tlen_q <= tlen; tx_busy <= 1'b1;
        tcnt <= '0; tidx <= '0; hold_full <= 1'b0;
      end else if (tx_busy && os_tick) begin
        if (tcnt == 4'd15) begin
          tcnt <= '0;
          if (tidx == tlen_q - 4'd1) tx_busy <= 1'b0;
          else begin
            tsh  <= {1'b1, tsh[12:1]};
            tidx <= tidx + 4'd1;
          end
        end else tcnt <= tcnt + 4'd1;
      end
      if (wr_txd) begin
        hold <= bus_wdata[8:0];
        hold_full <= 1'b1;
      end
    end
  end

  assign txd = brk_tx ? 1'b0 : (tx_busy ? tsh[0] : 1'b1);

  // receiver and status
  rx_state_e rstate;
  logic [3:0] rcnt, ridx;
  logic [9:0] rsh;
  logic [8:0] rx_buf, rx_data_w;
  logic rx_ready, ferr, perr, rx_brk, brk_prev, brk_delta, cts_delta, rx_pb;

  wire [3:0] rlen = nbits + {3'b0, par_en};
  wire rx_fin = (rstate == R_BITS) && os_tick && (rcnt == 4'd15) && (ridx == rlen);
  assign rx_data_w = rsh[8:0] & dmask;
  assign rx_pb     = rsh[nbits];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rstate <= R_IDLE; rcnt <= '0; ridx <= '0; rsh <= '0; rx_buf <= '0;
      rx_ready <= 1'b0; ferr <= 1'b0; perr <= 1'b0; rx_brk <= 1'b0;
      brk_prev <= 1'b0; brk_delta <= 1'b0; cts_delta <= 1'b0;
    end else begin
      brk_prev <= rx_brk;
      if (wr_stat) begin
        if (bus_wdata[5])  cts_delta <= 1'b0;
        if (bus_wdata[11]) brk_delta <= 1'b0;
        if (bus_wdata[13]) ferr <= 1'b0;
        if (bus_wdata[14]) perr <= 1'b0;
      end
      if (cts_s != cts_prev) cts_delta <= 1'b1;
      if (rx_brk != brk_prev) brk_delta <= 1'b1;
      if (rd_rxd) rx_ready <= 1'b0;
      case (rstate)
        R_IDLE:
          if (rx_brk) begin
            if (rx_s) rx_brk <= 1'b0;
          end else if (en && os_tick && !rx_s) begin
            rstate <= R_START; rcnt <= '0; ridx <= '0; rsh <= '0;
          end
        R_START:
          if (os_tick) begin
            if (rcnt == 4'd7) begin
              rcnt <= '0;
              rstate <= rx_s ? R_IDLE : R_BITS;
            end else rcnt <= rcnt + 4'd1;
          end
        R_BITS:
          if (os_tick) begin
            if (rcnt == 4'd15) begin
              rcnt <= '0;
              if (ridx == rlen) begin
                rstate   <= R_IDLE;
                rx_ready <= 1'b1;
                rx_buf   <= rx_data_w;
                if (!rx_s) ferr <= 1'b1;
                if (par_en && ((^rx_data_w ^ rx_pb) != par_odd)) perr <= 1'b1;
                if (!rx_s && rsh == '0) rx_brk <= 1'b1;
              end else begin
                rsh[ridx] <= rx_s;
                ridx <= ridx + 4'd1;
              end
            end else rcnt <= rcnt + 4'd1;
          end
        default: rstate <= R_IDLE;
      endcase
    end
  end

  assign stat = {1'b0, perr, ferr, 1'b0, brk_delta, rx_brk, 4'b0, cts_delta,
                 2'b0, !hold_full, 1'b0, rx_ready};
  assign irq  = |(stat & ien);

  always_comb begin
    case (bus_addr)
      A_CFG:   bus_rdata = cfg;
      A_CTL:   bus_rdata = {14'b0, brk_tx, 1'b0};
      A_STAT:  bus_rdata = stat;
      A_IENS:  bus_rdata = ien;
      A_RXD:   bus_rdata = {7'b0, rx_buf};
      A_DIV:   bus_rdata = 16'(brg);
      default: bus_rdata = '0;
    endcase
  end

  assert_txrdy_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_txd |=> !stat[2]);
  assert_rxrdy_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rxd && !rx_fin) |=> !rx_ready);
  assert_cts_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_en && cts_s && !tx_busy) |=> !tx_busy);
  assert_ien_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_iens && bus_wdata[0]) |=> ien[0]);
  assert_disabled_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !tx_busy) |=> !tx_busy);
  assert_break_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_brk && rstate == R_IDLE) |=> rstate == R_IDLE);
endmodule

// File: tb/serial_port_tb_top.sv
module serial_port_tb_top;
  logic clk = 0, rst_n = 0, tick_16x = 1;
  logic [2:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic rxd = 1, cts_n = 1, txd, irq;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  serial_port dut_i (.clk(clk), .rst_n(rst_n), .tick_16x(tick_16x), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rxd(rxd), .txd(txd), .cts_n(cts_n), .irq(irq));

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 v = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [15:0] v);
    bus_addr = a; #1 v = bus_rdata;
  endtask

  task automatic send_rx(input logic [8:0] d, input int nb, input bit par, input bit odd,
                         input bit bad_par, input bit stop_low, input int brg);
    int bl = 16 * (brg + 1);
    logic p = odd;
    for (int i = 0; i < nb; i++) p ^= d[i];
    if (bad_par) p = ~p;
    @(negedge clk); rxd = 0; repeat (bl) @(negedge clk);
    for (int i = 0; i < nb; i++) begin rxd = d[i]; repeat (bl) @(negedge clk); end
    if (par) begin rxd = p; repeat (bl) @(negedge clk); end
    rxd = ~stop_low; repeat (bl) @(negedge clk);
    rxd = 1; repeat (bl) @(negedge clk);
  endtask

  task automatic capture_tx(input int nb, input bit par, input int nstop, input int brg,
                            output logic [8:0] d, output logic pb, output logic stops_ok, output logic seen);
    int bl = 16 * (brg + 1);
    int guard = 0;
    d = 0; pb = 0; stops_ok = 1; seen = 0;
    while (txd !== 1'b0 && guard < 20000) begin @(negedge clk); guard++; end
    if (txd !== 1'b0) return;
    seen = 1;
    repeat (bl / 2) @(negedge clk);
    for (int i = 0; i < nb; i++) begin repeat (bl) @(negedge clk); d[i] = txd; end
    if (par) begin repeat (bl) @(negedge clk); pb = txd; end
    for (int i = 0; i < nstop; i++) begin repeat (bl) @(negedge clk); if (txd !== 1'b1) stops_ok = 0; end
  endtask

  task automatic t_reset;
    logic [15:0] v;
    chk("R1", "txd", {15'b0, txd}, 16'h1);
    chk("R1", "irq", {15'b0, irq}, 16'h0);
    peek(3'd2, v); chk("R1", "status", v, 16'h0004);
    peek(3'd0, v); chk("R1", "config", v, 16'h0000);
    peek(3'd1, v); chk("R1", "control", v, 16'h0000);
    peek(3'd3, v); chk("R1", "enables", v, 16'h0000);
  endtask

  task automatic t_tx_basic;
    logic [15:0] v; logic [8:0] d; logic pb, ok, seen;
    wr(3'd0, 16'h0005);
    wr(3'd6, 16'h00A5);
    peek(3'd2, v); chk("R5", "txready after write", {15'b0, v[2]}, 16'h0);
    capture_tx(8, 0, 1, 0, d, pb, ok, seen);
    chk("R3", "8N1 start seen", {15'b0, seen}, 16'h1);
    chk("R3", "8N1 data", {7'b0, d}, 16'h00A5);
    chk("R4", "8N1 stop", {15'b0, ok}, 16'h1);
    peek(3'd2, v); chk("R5", "txready after load", {15'b0, v[2]}, 16'h1);
  endtask

  task automatic t_tx_formats;
    logic [8:0] d; logic pb, ok, seen;
    wr(3'd0, 16'h0061);
    wr(3'd6, 16'h005B);
    capture_tx(7, 1, 2, 0, d, pb, ok, seen);
    chk("R3", "7-bit data", {7'b0, d}, 16'h005B);
    chk("R4", "even parity bit", {15'b0, pb}, 16'h1);
    chk("R4", "two stop bits", {15'b0, ok}, 16'h1);
    wr(3'd0, 16'h0039);
    wr(3'd6, 16'h01A5);
    capture_tx(9, 1, 1, 0, d, pb, ok, seen);
    chk("R3", "9-bit data", {7'b0, d}, 16'h01A5);
    chk("R4", "odd parity bit", {15'b0, pb}, 16'h0);
    chk("R4", "9O1 stop", {15'b0, ok}, 16'h1);
    wr(3'd0, 16'h0015);
    wr(3'd6, 16'h003C);
    capture_tx(8, 1, 1, 0, d, pb, ok, seen);
    chk("R4", "parity code 1 data", {7'b0, d}, 16'h003C);
    chk("R4", "parity code 1 no parity bit (0x3C)", {15'b0, pb}, 16'h1);
    wr(3'd6, 16'h003D);
    capture_tx(8, 1, 1, 0, d, pb, ok, seen);
    chk("R4", "parity code 1 no parity bit (0x3D)", {15'b0, pb}, 16'h1);
    wr(3'd0, 16'h000D);
    wr(3'd6, 16'h00C3);
    capture_tx(8, 0, 1, 0, d, pb, ok, seen);
    chk("R3", "length code 3 acts as 8", {7'b0, d}, 16'h00C3);
  endtask

  task automatic t_baud;
    logic [15:0] v; int n = 0;
    wr(3'd7, 16'h0002);
    peek(3'd7, v); chk("R2", "divider readback", v, 16'h0002);
    wr(3'd0, 16'h0005);
    wr(3'd6, 16'h000F);
    while (txd !== 1'b0 && n < 2000) begin @(negedge clk); n++; end
    n = 0;
    while (txd !== 1'b1 && n < 2000) begin @(negedge clk); n++; end
    n = 0;
    while (txd !== 1'b0 && n < 2000) begin @(negedge clk); n++; end
    chk("R2", "four bit periods at BRG=2", 16'(n), 16'd192);
    repeat (48 * 8) @(negedge clk);
    wr(3'd7, 16'h0000);
  endtask

  task automatic t_rx;
    logic [15:0] v;
    wr(3'd0, 16'h0005);
    send_rx(9'h096, 8, 0, 0, 0, 0, 0);
    peek(3'd2, v); chk("R6", "rxready set", {15'b0, v[0]}, 16'h1);
    rd(3'd5, v); chk("R6", "rx data 8N1", v, 16'h0096);
    peek(3'd2, v); chk("R6", "rxready cleared by read", {15'b0, v[0]}, 16'h0);
    wr(3'd0, 16'h0029);
    send_rx(9'h155, 9, 1, 0, 0, 0, 0);
    rd(3'd5, v); chk("R6", "rx data 9E1", v, 16'h0155);
    peek(3'd2, v); chk("R7", "no parity error on good frame", {15'b0, v[14]}, 16'h0);
    @(negedge clk); rxd = 0; repeat (4) @(negedge clk); rxd = 1;
    repeat (40) @(negedge clk);
    peek(3'd2, v); chk("R6", "short low pulse ignored", {15'b0, v[0]}, 16'h0);
  endtask

  task automatic t_errors;
    logic [15:0] v;
    wr(3'd0, 16'h0025);
    send_rx(9'h03A, 8, 1, 0, 1, 0, 0);
    peek(3'd2, v); chk("R7", "parity error flag", {15'b0, v[14]}, 16'h1);
    rd(3'd5, v);
    wr(3'd2, 16'h4000);
    peek(3'd2, v); chk("R7", "parity error cleared by W1C", {15'b0, v[14]}, 16'h0);
    wr(3'd0, 16'h0005);
    send_rx(9'h071, 8, 0, 0, 0, 1, 0);
    peek(3'd2, v); chk("R7", "framing error flag", {15'b0, v[13]}, 16'h1);
    rd(3'd5, v);
    wr(3'd2, 16'h2000);
    peek(3'd2, v); chk("R7", "framing error cleared by W1C", {15'b0, v[13]}, 16'h0);
  endtask

  task automatic t_cts;
    logic [15:0] v; logic [8:0] d; logic pb, ok, seen; int lows = 0;
    wr(3'd0, 16'h0205);
    wr(3'd6, 16'h0055);
    repeat (100) begin @(negedge clk); if (txd !== 1'b1) lows++; end
    chk("R8", "no start while cts deasserted", 16'(lows), 16'd0);
    peek(3'd2, v); chk("R8", "no cts change flag yet", {15'b0, v[5]}, 16'h0);
    cts_n = 0;
    capture_tx(8, 0, 1, 0, d, pb, ok, seen);
    chk("R8", "frame after cts asserted", {7'b0, d}, 16'h0055);
    peek(3'd2, v); chk("R8", "cts change flag", {15'b0, v[5]}, 16'h1);
    wr(3'd2, 16'h0020);
    peek(3'd2, v); chk("R8", "cts change flag W1C", {15'b0, v[5]}, 16'h0);
  endtask

  task automatic t_break_tx;
    int highs = 0;
    wr(3'd0, 16'h0005);
    wr(3'd1, 16'h0002);
    repeat (50) begin if (txd !== 1'b0) highs++; @(negedge clk); end
    chk("R9", "txd held low during break", 16'(highs), 16'd0);
    wr(3'd1, 16'h0000);
    chk("R9", "txd released", {15'b0, txd}, 16'h1);
  endtask

  task automatic t_break_rx;
    logic [15:0] v;
    wr(3'd0, 16'h0005);
    @(negedge clk); rxd = 0;
    repeat (16 * 14) @(negedge clk);
    peek(3'd2, v); chk("R10", "break flag", {15'b0, v[10]}, 16'h1);
    chk("R10", "break change flag", {15'b0, v[11]}, 16'h1);
    rd(3'd5, v);
    repeat (16 * 16) @(negedge clk);
    peek(3'd2, v); chk("R10", "no frame during break", {15'b0, v[0]}, 16'h0);
    rxd = 1;
    repeat (6) @(negedge clk);
    peek(3'd2, v); chk("R10", "break flag clears on high line", {15'b0, v[10]}, 16'h0);
    wr(3'd2, 16'h6820);
    peek(3'd2, v); chk("R10", "change flag W1C", {15'b0, v[11]}, 16'h0);
  endtask

  task automatic t_irq;
    logic [15:0] v;
    wr(3'd3, 16'h0005);
    peek(3'd3, v); chk("R11", "enables readback", v, 16'h0005);
    chk("R12", "irq from tx ready", {15'b0, irq}, 16'h1);
    wr(3'd4, 16'h0004);
    peek(3'd3, v); chk("R11", "enable cleared", v, 16'h0001);
    chk("R12", "irq low with only rx enabled", {15'b0, irq}, 16'h0);
    send_rx(9'h0E7, 8, 0, 0, 0, 0, 0);
    chk("R12", "irq from rx ready", {15'b0, irq}, 16'h1);
    rd(3'd5, v);
    chk("R12", "irq low after read", {15'b0, irq}, 16'h0);
    wr(3'd4, 16'h0001);
    peek(3'd3, v); chk("R11", "all enables cleared", v, 16'h0000);
  endtask

  task automatic t_disable;
    logic [15:0] v; logic [8:0] d; logic pb, ok, seen; int lows = 0;
    wr(3'd0, 16'h0004);
    wr(3'd6, 16'h0033);
    repeat (300) begin @(negedge clk); if (txd !== 1'b1) lows++; end
    chk("R13", "no frame while disabled", 16'(lows), 16'd0);
    peek(3'd2, v); chk("R13", "character held", {15'b0, v[2]}, 16'h0);
    send_rx(9'h0AA, 8, 0, 0, 0, 0, 0);
    peek(3'd2, v); chk("R13", "rx ignored while disabled", {15'b0, v[0]}, 16'h0);
    wr(3'd0, 16'h0005);
    capture_tx(8, 0, 1, 0, d, pb, ok, seen);
    chk("R13", "held character sent on enable", {7'b0, d}, 16'h0033);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_tx_basic();
    t_tx_formats();
    t_baud();
    t_rx();
    t_errors();
    t_cts();
    wr(3'd2, 16'h6820);
    t_break_tx();
    t_break_rx();
    t_irq();
    t_disable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule